// File: doc/BRIEF.md
# Per-Virtual-Channel Credit Backpressure Link

This block is the sending half of credit-based backpressure for a single router output port that carries several virtual channels (VCs). For every downstream VC it holds a counter of free buffer slots. A flit offered on a VC is granted only while that VC's counter is nonzero. Each grant uses one credit. A credit comes back when the downstream side removes a flit from that VC's buffer.

So that the whole loop can be exercised as one unit, the block also contains a model of the far end. A registered forward link of configurable latency carries granted flits into one FIFO per VC. A consumer pops those FIFOs. Each pop travels back over a registered credit path of configurable latency and raises the matching counter. The round trip seen by one buffer slot is the forward latency plus the credit latency plus two cycles, one for the FIFO write and one for the counter update. When the rate check option is enabled, elaboration refuses any buffer depth below that round trip, because a smaller depth cannot keep a VC busy every cycle. Route computation, VC selection policy and switch arbitration belong to neighbouring blocks.

Top module: `vc_credit_link`

## Requirements
- R1: After reset every per-VC credit counter equals DEPTH, and every downstream FIFO is empty.
- R2: A grant on VC v lowers counter v by exactly one in the next cycle and leaves every other counter alone, unless a credit for v returns in the same cycle.
- R3: `send_grant` is high only when `send_req` is high and the counter of `send_vc` is nonzero. A request on a VC whose counter is zero is neither granted nor forwarded.
- R4: A flit granted in cycle c can be popped from its VC's FIFO starting in cycle c+FWD_LAT+1. Flits leave each VC in grant order with their data unchanged. `dn_pop_ok` is high exactly when `dn_pop_req` is high and the FIFO selected by `dn_pop_vc` holds a flit, and `dn_pop_data` is then the oldest flit of that FIFO.
- R5: A successful pop on VC v in cycle c raises counter v, and the new value is visible in cycle c+CRD_LAT+1.
- R6: When a grant and a returning credit hit the same VC in the same cycle, that counter keeps its value.
- R7: With DEPTH >= FWD_LAT+CRD_LAT+2, a single VC that is requested every cycle and popped every cycle is granted in every cycle, and its counter settles at DEPTH-(FWD_LAT+CRD_LAT+2)+1.
- R8: A pop request on an empty VC FIFO produces no `dn_pop_ok` and returns no credit.
- R9: No credit return ever arrives for a VC whose counter already equals DEPTH.
- R10: A VC with a zero counter does not hold back grants on any other VC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| send_req | input | 1 | A flit is offered for sending |
| send_vc | input | VCW | VC of the offered flit |
| send_data | input | FLIT_W | Payload of the offered flit |
| send_grant | output | 1 | The offered flit is accepted this cycle |
| credit_count | output | NUM_VC*CW | Credit counters, VC v in bits [v*CW +: CW] |
| dn_pop_req | input | 1 | Downstream consumer wants to take a flit |
| dn_pop_vc | input | VCW | VC the consumer takes from |
| dn_pop_ok | output | 1 | A flit is taken this cycle |
| dn_pop_data | output | FLIT_W | Payload of the flit taken |

## Verification
The link is driven with four kinds of traffic. A burst on one VC with no draining shows whether the grant stops at exactly DEPTH flits, and whether another VC still gets through. A single isolated pop shows the exact cycle in which its credit lands. Pops on an empty VC show whether a phantom credit can appear. A continuous stream with continuous draining on one VC separates a correctly sized loop, which grants every cycle with a steady counter, from an off-by-one in the latency or in simultaneous update handling, which causes stalls or drift. A long pseudo-random mix across all VCs is compared cycle by cycle against a queue-based model and catches interference between VCs and ordering faults.

// File: rtl/vccf_pkg.sv
package vccf_pkg;

   // cycles one buffer slot is out of use: forward link, FIFO write,
   // credit path, counter update
   function automatic int vccf_rtt(input int fwd_lat, input int crd_lat);
      return fwd_lat + crd_lat + 2;
   endfunction

   // index width that never collapses to zero
   function automatic int vccf_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/vccf_delay_line.sv
module vccf_delay_line #(
   parameter int W   = 8,
   parameter int LAT = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (LAT < 0) begin : g_bad_lat
         $error("vccf_delay_line: LAT must not be negative");
      end

      if (LAT == 0) begin : g_wire
         assign q = d;
      end else begin : g_regs
         logic [W-1:0] stg [LAT];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < LAT; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
            end
         end

         assign q = stg[LAT-1];
      end
   endgenerate

endmodule

// File: rtl/vccf_credit_ctr.sv
module vccf_credit_ctr #(
   parameter int DEPTH = 6,
   parameter int CW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          give,
   output logic [CW-1:0] level,
   output logic          has_credit
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   generate
      if ((1 << CW) <= DEPTH) begin : g_bad_cw
         $error("vccf_credit_ctr: CW too narrow for DEPTH");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= FULL;
      end else begin
         unique case ({take, give})
            2'b10:   level <= level - 1'b1;
            2'b01:   level <= level + 1'b1;
            default: level <= level;
         endcase
      end
   end

   assign has_credit = (level != '0);

endmodule

// File: rtl/vccf_vc_fifo.sv
module vccf_vc_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 6,
   parameter int CW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic [CW-1:0] fill
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr;
   logic [PW-1:0] rd_ptr;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == LAST) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push) wr_ptr <= bump(wr_ptr);
         if (pop)  rd_ptr <= bump(rd_ptr);
         unique case ({push, pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   assign empty = (fill == '0);
   assign dout  = mem[rd_ptr];

endmodule

// File: rtl/vc_credit_link.sv
module vc_credit_link
   import vccf_pkg::*;
#(
   parameter int NUM_VC     = 4,
   parameter int DEPTH      = 6,
   parameter int FLIT_W     = 16,
   parameter int FWD_LAT    = 1,
   parameter int CRD_LAT    = 3,
   parameter bit RATE_CHECK = 1'b1,
   localparam int VCW       = vccf_idx_w(NUM_VC),
   localparam int CW        = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 send_req,
   input  logic [VCW-1:0]       send_vc,
   input  logic [FLIT_W-1:0]    send_data,
   output logic                 send_grant,
   output logic [NUM_VC*CW-1:0] credit_count,
   input  logic                 dn_pop_req,
   input  logic [VCW-1:0]       dn_pop_vc,
   output logic                 dn_pop_ok,
   output logic [FLIT_W-1:0]    dn_pop_data
);

   localparam int RTT   = vccf_rtt(FWD_LAT, CRD_LAT);
   localparam int LINKW = 1 + VCW + FLIT_W;
   localparam int CRDW  = 1 + VCW;

   // elaboration checks
   generate
      if (NUM_VC < 1) begin : g_bad_nvc
         $error("vc_credit_link: NUM_VC must be at least 1");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("vc_credit_link: DEPTH must be at least 1");
      end
      if (FLIT_W < 1) begin : g_bad_w
         $error("vc_credit_link: FLIT_W must be at least 1");
      end
      if (FWD_LAT < 0 || CRD_LAT < 0) begin : g_bad_lat
         $error("vc_credit_link: latencies must not be negative");
      end
      if (RATE_CHECK && (DEPTH < RTT)) begin : g_short_buf
         $error("vc_credit_link: DEPTH below credit round trip, full rate impossible");
      end
   endgenerate

   // upstream credit side
   logic [NUM_VC-1:0] req_hit;
   logic [NUM_VC-1:0] vc_has_credit;
   logic [NUM_VC-1:0] take_credit;
   logic [NUM_VC-1:0] give_credit;
   logic [CW-1:0]     ctr_level [NUM_VC];

   // forward link
   logic [LINKW-1:0]  link_in;
   logic [LINKW-1:0]  link_out;
   logic              lk_valid;
   logic [VCW-1:0]    lk_vc;
   logic [FLIT_W-1:0] lk_data;

   // downstream buffers
   logic [NUM_VC-1:0] buf_push;
   logic [NUM_VC-1:0] buf_pop;
   logic [NUM_VC-1:0] buf_empty;
   logic [FLIT_W-1:0] buf_dout [NUM_VC];
   logic [CW-1:0]     buf_fill [NUM_VC];
   logic [NUM_VC*CW-1:0] occ_flat;

   // credit return path
   logic [CRDW-1:0]   crd_in;
   logic [CRDW-1:0]   crd_out;
   logic              crd_valid;
   logic [VCW-1:0]    crd_vc;

   genvar v;
   generate
      for (v = 0; v < NUM_VC; v++) begin : g_vc
         assign req_hit[v]     = send_req && (send_vc == VCW'(v));
         assign take_credit[v] = req_hit[v] && vc_has_credit[v];
         assign give_credit[v] = crd_valid && (crd_vc == VCW'(v));

         vccf_credit_ctr #(
            .DEPTH (DEPTH),
            .CW    (CW)
         ) u_ctr (
            .clk        (clk),
            .rst_n      (rst_n),
            .take       (take_credit[v]),
            .give       (give_credit[v]),
            .level      (ctr_level[v]),
            .has_credit (vc_has_credit[v])
         );

         assign credit_count[v*CW +: CW] = ctr_level[v];

         assign buf_push[v] = lk_valid && (lk_vc == VCW'(v));
         assign buf_pop[v]  = dn_pop_req && (dn_pop_vc == VCW'(v)) && !buf_empty[v];

         vccf_vc_fifo #(
            .W     (FLIT_W),
            .DEPTH (DEPTH),
            .CW    (CW)
         ) u_buf (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (buf_push[v]),
            .din   (lk_data),
            .pop   (buf_pop[v]),
            .dout  (buf_dout[v]),
            .empty (buf_empty[v]),
            .fill  (buf_fill[v])
         );

         assign occ_flat[v*CW +: CW] = buf_fill[v];
      end
   endgenerate

   assign send_grant = |take_credit;

   assign link_in = {send_grant, send_vc, send_data};

   vccf_delay_line #(
      .W   (LINKW),
      .LAT (FWD_LAT)
   ) u_fwd (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (link_in),
      .q     (link_out)
   );

   assign {lk_valid, lk_vc, lk_data} = link_out;

   assign dn_pop_ok = |buf_pop;

   always_comb begin
      dn_pop_data = '0;
      for (int i = 0; i < NUM_VC; i++) begin
         if (buf_pop[i]) dn_pop_data = buf_dout[i];
      end
   end

   assign crd_in = {dn_pop_ok, dn_pop_vc};

   vccf_delay_line #(
      .W   (CRDW),
      .LAT (CRD_LAT)
   ) u_crd (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (crd_in),
      .q     (crd_out)
   );

   assign {crd_valid, crd_vc} = crd_out;

endmodule

// File: rtl/vccf_checker.sv
module vccf_checker #(
   parameter int NUM_VC = 4,
   parameter int DEPTH  = 6,
   parameter int VCW    = 2,
   parameter int CW     = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 send_req,
   input logic [VCW-1:0]       send_vc,
   input logic                 send_grant,
   input logic [NUM_VC*CW-1:0] credit_count,
   input logic                 crd_valid,
   input logic [VCW-1:0]       crd_vc,
   input logic                 lk_valid,
   input logic [VCW-1:0]       lk_vc,
   input logic [NUM_VC*CW-1:0] occ_flat,
   input logic                 dn_pop_ok,
   input logic [VCW-1:0]       dn_pop_vc
);

   function automatic int sl(input logic [NUM_VC*CW-1:0] f, input logic [VCW-1:0] i);
      return int'(f[int'(i)*CW +: CW]);
   endfunction

   logic same_vc_hit;
   assign same_vc_hit = send_grant && crd_valid && (send_vc == crd_vc);

   AST_NO_GRANT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (send_req && sl(credit_count, send_vc) == 0) |-> !send_grant); // R3

   AST_DEC_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (send_grant && !same_vc_hit) |=>
      sl(credit_count, $past(send_vc)) == sl($past(credit_count), $past(send_vc)) - 1); // R2

   AST_INC_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (crd_valid && !same_vc_hit) |=>
      sl(credit_count, $past(crd_vc)) == sl($past(credit_count), $past(crd_vc)) + 1); // R5

   AST_SAME_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      same_vc_hit |=>
      sl(credit_count, $past(send_vc)) == sl($past(credit_count), $past(send_vc))); // R6

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      crd_valid |-> sl(credit_count, crd_vc) < DEPTH); // R9

   AST_BUF_NEVER_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> sl(occ_flat, lk_vc) < DEPTH); // R3

   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      dn_pop_ok |-> sl(occ_flat, dn_pop_vc) != 0); // R8

endmodule

bind vc_credit_link vccf_checker #(
   .NUM_VC (NUM_VC),
   .DEPTH  (DEPTH),
   .VCW    (VCW),
   .CW     (CW)
) u_vccf_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .send_req     (send_req),
   .send_vc      (send_vc),
   .send_grant   (send_grant),
   .credit_count (credit_count),
   .crd_valid    (crd_valid),
   .crd_vc       (crd_vc),
   .lk_valid     (lk_valid),
   .lk_vc        (lk_vc),
   .occ_flat     (occ_flat),
   .dn_pop_ok    (dn_pop_ok),
   .dn_pop_vc    (dn_pop_vc)
);

// File: tb/tb_vc_credit_link.sv
module tb_vc_credit_link;

   localparam int NUM_VC  = 4;
   localparam int DEPTH   = 6;
   localparam int FLIT_W  = 16;
   localparam int FWD_LAT = 1;
   localparam int CRD_LAT = 3;
   localparam int VCW     = 2;
   localparam int CW      = 3;
   localparam int RTT     = FWD_LAT + CRD_LAT + 2;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 send_req = 1'b0;
   logic [VCW-1:0]       send_vc = '0;
   logic [FLIT_W-1:0]    send_data = '0;
   logic                 send_grant;
   logic [NUM_VC*CW-1:0] credit_count;
   logic                 dn_pop_req = 1'b0;
   logic [VCW-1:0]       dn_pop_vc = '0;
   logic                 dn_pop_ok;
   logic [FLIT_W-1:0]    dn_pop_data;

   always #2 clk = ~clk;

   vc_credit_link #(
      .NUM_VC  (NUM_VC),
      .DEPTH   (DEPTH),
      .FLIT_W  (FLIT_W),
      .FWD_LAT (FWD_LAT),
      .CRD_LAT (CRD_LAT)
   ) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .send_req     (send_req),
      .send_vc      (send_vc),
      .send_data    (send_data),
      .send_grant   (send_grant),
      .credit_count (credit_count),
      .dn_pop_req   (dn_pop_req),
      .dn_pop_vc    (dn_pop_vc),
      .dn_pop_ok    (dn_pop_ok),
      .dn_pop_data  (dn_pop_data)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // reference model state
   int mcnt [NUM_VC];
   int fq   [NUM_VC][$];
   int pv[$], pd[$], pt[$];
   int cv[$], ct[$];
   int cyc = 0;
   int seq = 1;
   bit g_seen, p_seen;

   task automatic chk(input string rq, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
      end
   endtask

   function automatic int dcnt(input int v);
      return int'(credit_count[v*CW +: CW]);
   endfunction

   task automatic step(input bit rq, input int vc, input bit pq, input int pvc);
      bit eg, ep;
      int ed;
      @(negedge clk);
      while (pt.size() > 0 && pt[0] <= cyc) begin
         fq[pv[0]].push_back(pd[0]);
         void'(pv.pop_front()); void'(pd.pop_front()); void'(pt.pop_front());
      end
      while (ct.size() > 0 && ct[0] <= cyc) begin
         mcnt[cv[0]]++;
         void'(cv.pop_front()); void'(ct.pop_front());
      end
      send_req   = rq;
      send_vc    = VCW'(vc);
      send_data  = FLIT_W'(seq);
      dn_pop_req = pq;
      dn_pop_vc  = VCW'(pvc);
      #1;
      eg = rq && (mcnt[vc] > 0);
      ep = pq && (fq[pvc].size() > 0);
      ed = ep ? fq[pvc][0] : 0;
      chk("R3 grant", int'(send_grant), int'(eg));
      for (int v = 0; v < NUM_VC; v++) chk("R2 credit count", dcnt(v), mcnt[v]);
      chk("R4 pop ok", int'(dn_pop_ok), int'(ep));
      if (ep) chk("R4 pop data", int'(dn_pop_data), ed);
      g_seen = send_grant;
      p_seen = dn_pop_ok;
      if (eg) begin
         mcnt[vc]--;
         pv.push_back(vc); pd.push_back(seq & 16'hFFFF); pt.push_back(cyc + FWD_LAT + 1);
      end
      if (ep) begin
         void'(fq[pvc].pop_front());
         cv.push_back(pvc); ct.push_back(cyc + CRD_LAT + 1);
      end
      seq++;
      cyc++;
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      int grants, c_mid, c_end;
      logic [15:0] lfsr;
      for (int v = 0; v < NUM_VC; v++) mcnt[v] = DEPTH;
      repeat (4) @(negedge clk);
      #1;
      for (int v = 0; v < NUM_VC; v++) chk("R1 reset credit", dcnt(v), DEPTH);
      chk("R1 reset no pop", int'(dn_pop_ok), 0);
      rst_n = 1'b1;

      // burst on VC0 without draining
      grants = 0;
      for (int i = 0; i < DEPTH + 2; i++) begin
         step(1, 0, 0, 0);
         grants += int'(g_seen);
      end
      chk("R3 burst grants stop at depth", grants, DEPTH);
      step(0, 0, 0, 0);
      chk("R2 vc0 exhausted", dcnt(0), 0);
      step(1, 1, 0, 0);
      chk("R10 other vc still granted", int'(g_seen), 1);
      step(1, 0, 0, 0);
      chk("R3 zero credit refused", int'(g_seen), 0);

      // single pop, exact return cycle
      step(0, 0, 1, 0);
      chk("R4 pop of stored flit", int'(p_seen), 1);
      for (int k = 1; k <= CRD_LAT + 1; k++) begin
         step(0, 0, 0, 0);
         chk("R5 credit return timing", dcnt(0), (k == CRD_LAT + 1) ? 1 : 0);
      end

      // pops on an empty VC
      for (int i = 0; i < 3; i++) begin
         step(0, 0, 1, 2);
         chk("R8 empty pop refused", int'(p_seen), 0);
      end
      for (int i = 0; i < CRD_LAT + 2; i++) step(0, 0, 0, 0);
      chk("R8 no phantom credit", dcnt(2), DEPTH);

      // full-rate stream on VC3
      grants = 0;
      c_mid = -1;
      c_end = -1;
      for (int i = 0; i < 40; i++) begin
         step(1, 3, 1, 3);
         grants += int'(g_seen);
         if (i == 20) c_mid = dcnt(3);
         if (i == 39) c_end = dcnt(3);
      end
      chk("R7 grant every cycle", grants, 40);
      chk("R6 steady count", c_end, c_mid);
      chk("R7 steady level", c_end, DEPTH - RTT + 1);

      // pseudo-random mix
      lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0], int'(lfsr[3:2]), lfsr[5] | lfsr[6], int'(lfsr[9:8]));
      end

      // drain and confirm every credit came home
      for (int i = 0; i < 80; i++) step(0, 0, 1, i % NUM_VC);
      for (int i = 0; i < CRD_LAT + 3; i++) step(0, 0, 0, 0);
      for (int v = 0; v < NUM_VC; v++) chk("R5 all credits restored", dcnt(v), DEPTH);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule